// File: doc/BRIEF.md
# I2C Transmit Queue Drain Engine

This block sits between a register interface and an I2C byte transmitter. Software writes bytes through a push port into a 64-entry byte queue, but only while the queue is switched on through a control write. Whenever the queue is switched on and holds data, the engine takes the oldest byte and offers it to the transmitter over a valid/ready handshake. It then waits for the transmitter's acknowledge result before offering the next byte. The transmitter itself is outside the block; here it is only a handshake partner that returns one ack-or-nak result per byte.

When the target does not acknowledge a byte, draining stops. The bytes that were not sent stay in the queue until software flushes it through the control write. The engine keeps three sticky event flags that software clears by writing ones: a target refusal, a completed drain, and a push that was dropped because the queue was full. A separate queue-status word shows whether the queue is empty.

Top module: `i2c_txq_drain`

## Requirements
- R1: After reset the event flags read 0, the queue level is 0, `tx_valid` is low and `fifo_stat` bit 4 reads 1.
- R2: A push is stored only while the queue is enabled (`ctl_wdata` bit 6 from the last control write). A push while disabled is ignored and leaves the level unchanged. The level never exceeds DEPTH.
- R3: A push while DEPTH bytes are stored is dropped and sets event flag bit 2 (overflow). The stored bytes are unaffected and later drain in order.
- R4: A control write with bit 7 set empties the queue and releases a refusal halt. Bit 6 of the same write sets the enable, so writing both leaves the queue empty and enabled. A push in the same cycle as a flush is discarded.
- R5: Bytes reach the transmitter in push order. `tx_valid` stays high with a stable `tx_byte` until `tx_ready`, and the next byte is offered only after a result has arrived for the previous one.
- R6: A result with `res_nak` high sets event flag bit 0 and stops draining. Unsent bytes, and bytes pushed afterwards, stay in the queue until a flush.
- R7: An acknowledge result that arrives while the queue holds no bytes sets event flag bit 1 (drained). A refusal never sets it.
- R8: `fifo_stat` bit 4 is 1 exactly when the level is 0. All other `fifo_stat` bits read 0.
- R9: A write on the flag-clear port clears each flag whose mask bit is 1 and leaves the others. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Data-register write strobe |
| push_data | input | DW (8) | Byte to queue |
| ctl_we | input | 1 | Queue control write strobe |
| ctl_wdata | input | 8 | Control word: bit 7 flush, bit 6 enable |
| clr_we | input | 1 | Event-flag clear strobe |
| clr_mask | input | 8 | Write-one-to-clear mask for the event flags |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_byte | output | DW (8) | Offered byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| res_valid | input | 1 | Transmitter returns the result for the last byte |
| res_nak | input | 1 | Result is a refusal |
| evt_flags | output | 8 | Bit 0 refusal, bit 1 drained, bit 2 overflow, others 0 |
| fifo_stat | output | 8 | Bit 4 queue empty, others 0 |
| fifo_level | output | $clog2(DEPTH+1) (7) | Bytes currently stored |

## Verification
A wrong read or write pointer shows at `tx_byte` as a byte out of order or a repeated byte, on the first drain that crosses the corrupted entry. A wrong occupancy count shows as a premature or missing drained flag, or as an overflow flag raised before 64 bytes are held. A refusal halt that is never set or never released shows within a few cycles: `tx_valid` rises again after a refusal, or stays low after a flush followed by fresh pushes. The sweeps over burst length, the full-queue fill and the refusal-then-flush sequence each trip on one of these symptoms.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int CTL_FLUSH_BIT = 7;
    localparam int CTL_EN_BIT    = 6;
    localparam int FST_EMPTY_BIT = 4;
    localparam int NUM_FLAGS     = 3;
    localparam int FLG_NAK       = 0;
    localparam int FLG_DRAINED   = 1;
    localparam int FLG_OVF       = 2;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_OFFER = 2'd1,
        DR_WAIT  = 2'd2
    } drain_st_e;

    typedef struct packed {
        logic ovf;
        logic drained;
        logic nak;
    } flag_ev_t;

    function automatic logic [NUM_FLAGS-1:0] ev_to_vec(flag_ev_t ev);
        logic [NUM_FLAGS-1:0] v;
        v = '0;
        v[FLG_NAK]     = ev.nak;
        v[FLG_DRAINED] = ev.drained;
        v[FLG_OVF]     = ev.ovf;
        return v;
    endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/txq_sequencer.sv
module txq_sequencer
    import txq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          flush,
    input  logic          fifo_empty,
    input  logic [DW-1:0] head,
    output logic          pop,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    input  logic          tx_ready,
    input  logic          res_valid,
    input  logic          res_nak,
    output logic          ev_nak,
    output logic          ev_drained
);
    drain_st_e     st_q, st_d;
    logic          halted_q, halted_d;
    logic [DW-1:0] byte_q;
    logic          got_result;

    assign tx_valid   = (st_q == DR_OFFER);
    assign tx_byte    = byte_q;
    assign pop        = (st_q == DR_IDLE) && enable && !fifo_empty && !halted_q && !flush;
    assign got_result = (st_q == DR_WAIT) && res_valid;
    assign ev_nak     = got_result && res_nak;
    assign ev_drained = got_result && !res_nak && fifo_empty;

    always_comb begin
        st_d     = st_q;
        halted_d = flush ? 1'b0 : halted_q;
        unique case (st_q)
            DR_IDLE:  if (pop) st_d = DR_OFFER;
            DR_OFFER: if (tx_ready) st_d = DR_WAIT;
            DR_WAIT:  if (res_valid) st_d = DR_IDLE;
            default:  st_d = DR_IDLE;
        endcase
        if (ev_nak) begin
            halted_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= DR_IDLE;
            halted_q <= 1'b0;
            byte_q   <= '0;
        end else begin
            st_q     <= st_d;
            halted_q <= halted_d;
            if (pop) begin
                byte_q <= head;
            end
        end
    end
endmodule

// File: rtl/txq_flags.sv
module txq_flags
    import txq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  flag_ev_t             ev,
    input  logic                 clr_we,
    input  logic [NUM_FLAGS-1:0] clr_bits,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [NUM_FLAGS-1:0] set_v;
    assign set_v = ev_to_vec(ev);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_v[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_we && clr_bits[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_txq_drain.sv
module i2c_txq_drain
    import txq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_valid,
    input  logic [DW-1:0]                push_data,
    input  logic                         ctl_we,
    input  logic [7:0]                   ctl_wdata,
    input  logic                         clr_we,
    input  logic [7:0]                   clr_mask,
    output logic                         tx_valid,
    output logic [DW-1:0]                tx_byte,
    input  logic                         tx_ready,
    input  logic                         res_valid,
    input  logic                         res_nak,
    output logic [7:0]                   evt_flags,
    output logic [7:0]                   fifo_stat,
    output logic [$clog2(DEPTH+1)-1:0]   fifo_level
);
    localparam int LW = $clog2(DEPTH + 1);

    logic                 en_q;
    logic                 flush;
    logic                 push_try, push_ok;
    logic                 pop;
    logic                 f_empty, f_full;
    logic [DW-1:0]        head;
    logic [LW-1:0]        level;
    logic [NUM_FLAGS-1:0] flags;
    flag_ev_t             ev;
    logic                 ev_nak, ev_drained;
    logic                 ctl_unused;

    assign ctl_unused = ^{ctl_wdata[5:0], clr_mask[7:NUM_FLAGS]};

    assign flush    = ctl_we && ctl_wdata[CTL_FLUSH_BIT];
    assign push_try = push_valid && en_q && !flush;
    assign push_ok  = push_try && !f_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (ctl_we) begin
            en_q <= ctl_wdata[CTL_EN_BIT];
        end
    end

    txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push_ok),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .level     (level),
        .empty     (f_empty),
        .full      (f_full)
    );

    txq_sequencer #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (en_q),
        .flush      (flush),
        .fifo_empty (f_empty),
        .head       (head),
        .pop        (pop),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .tx_ready   (tx_ready),
        .res_valid  (res_valid),
        .res_nak    (res_nak),
        .ev_nak     (ev_nak),
        .ev_drained (ev_drained)
    );

    always_comb begin
        ev.nak     = ev_nak;
        ev.drained = ev_drained;
        ev.ovf     = push_try && f_full;
    end

    txq_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .clr_we   (clr_we),
        .clr_bits (clr_mask[NUM_FLAGS-1:0]),
        .flags    (flags)
    );

    always_comb begin
        evt_flags = '0;
        evt_flags[NUM_FLAGS-1:0] = flags;
        fifo_stat = '0;
        fifo_stat[FST_EMPTY_BIT] = f_empty;
    end

    assign fifo_level = level;
endmodule

// File: rtl/txq_drain_chk.sv
module txq_drain_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push_valid,
    input logic          en_q,
    input logic          ctl_we,
    input logic [7:0]    ctl_wdata,
    input logic          tx_valid,
    input logic [DW-1:0] tx_byte,
    input logic          tx_ready,
    input logic          res_valid,
    input logic          res_nak,
    input logic [7:0]    evt_flags,
    input logic [7:0]    fifo_stat,
    input logic [LW-1:0] fifo_level
);
    // R2: occupancy bounded by the depth
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    // R3: a push into a full queue raises the overflow flag
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (push_valid && en_q && !(ctl_we && ctl_wdata[7]) && fifo_level == LW'(DEPTH))
        |=> evt_flags[2]);

    // R4: a flush leaves the queue empty
    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[7]) |=> (fifo_level == '0 && fifo_stat[4]));

    // R5: an offer is held with a stable byte until taken
    assert_offer_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R6: no new offer right after a refusal
    assert_halt_on_nak_R6: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && res_valid && res_nak) |=> !tx_valid);

    // R8: empty status bit tracks the level
    assert_empty_stat_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_stat[4] == (fifo_level == '0));
endmodule

bind i2c_txq_drain txq_drain_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .en_q       (en_q),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .tx_ready   (tx_ready),
    .res_valid  (res_valid),
    .res_nak    (res_nak),
    .evt_flags  (evt_flags),
    .fifo_stat  (fifo_stat),
    .fifo_level (fifo_level)
);

// File: tb/i2c_txq_drain_tb.sv
module i2c_txq_drain_tb;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          clr_we = 1'b0;
    logic [7:0]    clr_mask = '0;
    logic          tx_valid;
    logic [DW-1:0] tx_byte;
    logic          tx_ready = 1'b0;
    logic          res_valid = 1'b0;
    logic          res_nak = 1'b0;
    logic [7:0]    evt_flags;
    logic [7:0]    fifo_stat;
    logic [LW-1:0] fifo_level;

    int checks = 0;
    int fails  = 0;

    logic [7:0] rx_log [0:255];
    int   rx_cnt  = 0;
    bit   rdy_en  = 0;
    int   nak_at  = -1;
    logic [7:0] exp_b [0:255];

    always #4 clk = ~clk;

    i2c_txq_drain #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr_we(clr_we), .clr_mask(clr_mask),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .res_valid(res_valid), .res_nak(res_nak), .evt_flags(evt_flags),
        .fifo_stat(fifo_stat), .fifo_level(fifo_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // transmitter model: take the byte, then return one result
    initial begin
        forever begin
            @(negedge clk);
            res_valid = 1'b0;
            if (tx_valid && rdy_en) begin
                rx_log[rx_cnt[7:0]] = tx_byte;
                tx_ready = 1'b1;
                @(negedge clk);
                tx_ready  = 1'b0;
                res_valid = 1'b1;
                res_nak   = (rx_cnt == nak_at);
                rx_cnt++;
            end
        end
    end

    task automatic push1(input logic [7:0] b);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = b;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clr(input logic [7:0] m);
        @(negedge clk);
        clr_we = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int k = 0; k < 4000 && rx_cnt < n; k++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seen;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(evt_flags == 8'h00, "R1 flags", evt_flags, 0);
        chk(fifo_level == 0, "R1 level", fifo_level, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        chk(fifo_stat == 8'h10, "R1 R8 fifo_stat", fifo_stat, 16);

        // R2 push while disabled is ignored
        push1(8'hA5);
        repeat (3) @(negedge clk);
        chk(fifo_level == 0, "R2 disabled push", fifo_level, 0);
        chk(tx_valid == 1'b0, "R2 no offer when disabled", tx_valid, 0);

        // R5 R7 sweep of burst lengths
        ctl(8'hC0);
        for (int n = 1; n <= 10; n++) begin
            int len;
            len = (n == 10) ? DEPTH : n;
            rdy_en = 0;
            rx_cnt = 0;
            clr(8'hFF);
            for (int i = 0; i < len; i++) begin
                exp_b[i] = 8'((n * 37 + i * 11 + 3) & 255);
                push1(exp_b[i]);
            end
            repeat (2) @(negedge clk);
            chk(fifo_level == LW'(len - 1), "R2 level after fill", fifo_level, len - 1);
            chk(tx_valid == 1'b1, "R5 offer held without ready", tx_valid, 1);
            chk(evt_flags[1] == 1'b0, "R7 no drained while pending", evt_flags[1], 0);
            rdy_en = 1;
            wait_rx(len);
            rdy_en = 0;
            chk(rx_cnt == len, "R5 byte count", rx_cnt, len);
            ok = 1;
            for (int i = 0; i < len; i++) if (rx_log[i] != exp_b[i]) ok = 0;
            chk(ok, "R5 order", ok, 1);
            chk(evt_flags == 8'h02, "R7 drained flag", evt_flags, 2);
            chk(fifo_stat == 8'h10, "R8 empty after drain", fifo_stat, 16);
        end

        // R9 selective clear
        clr(8'h01);
        chk(evt_flags == 8'h02, "R9 clear other bit keeps", evt_flags, 2);
        clr(8'h02);
        chk(evt_flags == 8'h00, "R9 clear drained", evt_flags, 0);

        // R3 overflow
        rx_cnt = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            exp_b[i] = 8'((i * 29 + 5) & 255);
            push1(exp_b[i]);
        end
        @(negedge clk);
        chk(fifo_level == LW'(DEPTH), "R3 level full", fifo_level, DEPTH);
        chk(evt_flags[2] == 1'b1, "R3 overflow flag", evt_flags[2], 1);
        chk(fifo_stat == 8'h00, "R8 not empty", fifo_stat, 0);
        rdy_en = 1;
        wait_rx(DEPTH + 1);
        rdy_en = 0;
        chk(rx_cnt == DEPTH + 1, "R3 kept bytes count", rx_cnt, DEPTH + 1);
        ok = 1;
        for (int i = 0; i < DEPTH + 1; i++) if (rx_log[i] != exp_b[i]) ok = 0;
        chk(ok, "R3 kept bytes order", ok, 1);
        chk(evt_flags == 8'h06, "R3 R7 flags", evt_flags, 6);
        clr(8'h02);
        chk(evt_flags == 8'h04, "R9 partial clear", evt_flags, 4);
        clr(8'h04);
        chk(evt_flags == 8'h00, "R9 overflow clear", evt_flags, 0);

        // R6 refusal halts draining
        rx_cnt = 0;
        nak_at = 2;
        rdy_en = 1;
        for (int i = 0; i < 6; i++) push1(8'(8'h40 + i));
        wait_rx(3);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        chk(rx_cnt == 3, "R6 bytes sent before halt", rx_cnt, 3);
        chk(seen == 0, "R6 no offer after refusal", seen, 0);
        chk(fifo_level == 3, "R6 unsent bytes kept", fifo_level, 3);
        chk(evt_flags == 8'h01, "R6 R7 nak flag only", evt_flags, 1);
        push1(8'h77);
        repeat (6) @(negedge clk);
        chk(fifo_level == 4, "R6 push while halted kept", fifo_level, 4);
        chk(rx_cnt == 3, "R6 still halted", rx_cnt, 3);

        // R4 flush releases halt
        nak_at = -1;
        ctl(8'hC0);
        chk(fifo_level == 0, "R4 flush empties", fifo_level, 0);
        clr(8'hFF);
        rx_cnt = 0;
        push1(8'h91);
        push1(8'h92);
        wait_rx(2);
        chk(rx_cnt == 2, "R4 drain resumes", rx_cnt, 2);
        chk(rx_log[0] == 8'h91 && rx_log[1] == 8'h92, "R4 resumed bytes", rx_log[1], 8'h92);
        chk(evt_flags == 8'h02, "R4 R7 drained after resume", evt_flags, 2);

        // R4 flush with enable cleared disables pushes
        rdy_en = 0;
        ctl(8'h80);
        push1(8'h33);
        repeat (3) @(negedge clk);
        chk(fifo_level == 0, "R4 R2 flush without enable", fifo_level, 0);

        // R4 push in the same cycle as flush is discarded
        ctl(8'h40);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = 8'hC0;
        push_valid = 1'b1;
        push_data = 8'h55;
        @(negedge clk);
        ctl_we = 1'b0;
        push_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(fifo_level == 0 && tx_valid == 1'b0, "R4 push during flush dropped", fifo_level, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule